// File: doc/BRIEF.md
# Fast-Acquisition Timeout Sequencer

This block sequences the fast-acquisition phase of a frequency synthesizer loop after the host retunes it. The same register write that loads a new divider word pulses `tune`. That pulse puts the block into a boost state. While it boosts, the block does three things:

- It selects a higher charge-pump gain code.
- It closes the loop-filter switch output.
- It raises the comparison divide factor, which lowers the phase-detector comparison rate and so limits cycle slipping.

The block counts reference cycles of the phase detector, one for each `ref_tick` strobe. After a programmed number of them it returns to the steady-state settings by itself, with no further write from the host.

There is no data stream at the block's edge. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure. The analog charge pump, the dividers and the loop-filter switch itself are outside the block.

Top module: `acq_boost_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces the normal state with the cycle counter cleared. After reset, `busy` and `loop_sw` are 0, `gain_code` equals `norm_gain` and `cmp_div` equals 1. Reference ticks that arrive after reset do not start a boost.
- R2: A `tune` pulse sampled with a nonzero `timeout` sets `busy` and `loop_sw` to 1 from the next clock edge.
- R3: `gain_code` follows `boost_gain` while `busy` is 1 and follows `norm_gain` while `busy` is 0.
- R4: While `busy` is 1, `cmp_div` equals 2 to the power of `slip_code`: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. While `busy` is 0, `cmp_div` is 1.
- R5: The boost ends on the clock edge that samples the T-th `ref_tick` after the `tune` pulse, where T is the timeout captured at that pulse. Clock cycles without `ref_tick` are not counted.
- R6: A `tune` pulse sampled with `timeout` equal to 0 leaves the block in the normal state, or returns it there from the next edge if a boost is running.
- R7: A `tune` pulse during a boost restarts the count from the full value on `timeout` at that pulse.
- R8: `gain_code`, `cmp_div` and `loop_sw` return to their normal values on the same clock edge.
- R9: A `ref_tick` in the same cycle as a `tune` pulse is not counted; the restart takes precedence.
- R10: The full 14-bit timeout range is supported, so a timeout of 16383 lasts exactly 16383 ticks.
- R11: Changes on `timeout` after the `tune` pulse have no effect on the boost that is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle strobe for each phase-detector reference cycle |
| tune | input | 1 | One-cycle strobe issued with each new divider write |
| timeout | input | 14 | Boost length in reference cycles; 0 disables the boost |
| norm_gain | input | 2 | Steady-state charge-pump gain code (four levels) |
| boost_gain | input | 2 | Charge-pump gain code used during the boost |
| slip_code | input | 2 | Cycle-slip reduction selection |
| gain_code | output | 2 | Active charge-pump gain code |
| cmp_div | output | 4 | Comparison rate divide factor |
| loop_sw | output | 1 | Loop-filter switch control, 1 during the boost |
| busy | output | 1 | 1 while the boost is active |

## Verification
Every result of this block has one register between stimulus and output, the state register. A `tune` or the last `ref_tick` sampled at an edge therefore changes `busy`, `loop_sw`, `gain_code` and `cmp_div` straight after that same edge. `norm_gain` and `boost_gain` reach `gain_code` without any clock. The bench drives inputs on the falling edge and reads all outputs on the next falling edge, which is half a cycle after the edge that acts on them. For a timeout of T, it checks `busy` after T-1 ticks, with idle cycles between ticks, and expects the return only after the T-th.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int TO_W_DEF   = 14;
  localparam int GAIN_W_DEF = 2;
  localparam int CSR_W_DEF  = 2;

  typedef enum logic {
    ST_NORM  = 1'b0,
    ST_BOOST = 1'b1
  } acq_state_e;
endpackage

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int TO_W = acq_pkg::TO_W_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [TO_W-1:0] load_val,
  input  logic            tick,
  output logic            expire
);
  localparam logic [TO_W-1:0] ONE = TO_W'(1);

  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - ONE;
  end

  // the last pending reference cycle is consumed now, unless a reload overrides it
  assign expire = tick && !load && (cnt == ONE);

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val)); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && cnt == '0) |=> cnt == '0); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt)); // R5
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tune,
  input  logic to_nonzero,
  input  logic expire,
  output logic busy
);
  acq_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    if (tune)        state_nx = to_nonzero ? ST_BOOST : ST_NORM;
    else if (expire) state_nx = ST_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_NORM;
    else     state <= state_nx;
  end

  assign busy = (state == ST_BOOST);

  AST_START: assert property (@(posedge clk) disable iff (rst)
    (tune && to_nonzero) |=> busy); // R2

  AST_ZERO_STAYS_NORM: assert property (@(posedge clk) disable iff (rst)
    (tune && !to_nonzero) |=> !busy); // R6

  AST_HOLD_BOOST: assert property (@(posedge clk) disable iff (rst)
    (busy && !expire && !tune) |=> busy); // R5

  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && !tune) |=> !busy); // R1
endmodule

// File: rtl/acq_out_map.sv
module acq_out_map #(
  parameter int GAIN_W = acq_pkg::GAIN_W_DEF,
  parameter int CSR_W  = acq_pkg::CSR_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busy,
  input  logic [GAIN_W-1:0]     norm_gain,
  input  logic [GAIN_W-1:0]     boost_gain,
  input  logic [CSR_W-1:0]      slip_code,
  output logic [GAIN_W-1:0]     gain_code,
  output logic [(1<<CSR_W)-1:0] cmp_div,
  output logic                  loop_sw
);
  localparam int DIV_W = 1 << CSR_W;

  logic [DIV_W-1:0] factor;

  // one bit per slip code: the set bit gives the power-of-two divide factor
  for (genvar i = 0; i < DIV_W; i++) begin : g_factor
    assign factor[i] = (slip_code == CSR_W'(i));
  end

  assign gain_code = busy ? boost_gain : norm_gain;
  assign cmp_div   = busy ? factor : DIV_W'(1);
  assign loop_sw   = busy;

  AST_DIV_POW2: assert property (@(posedge clk) disable iff (rst)
    $countones(cmp_div) == 1); // R4

  AST_NORM_DIV_ONE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cmp_div == DIV_W'(1)); // R4
endmodule

// File: rtl/acq_boost_ctrl.sv
module acq_boost_ctrl #(
  parameter int TO_W   = acq_pkg::TO_W_DEF,
  parameter int GAIN_W = acq_pkg::GAIN_W_DEF,
  parameter int CSR_W  = acq_pkg::CSR_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_tick,
  input  logic                  tune,
  input  logic [TO_W-1:0]       timeout,
  input  logic [GAIN_W-1:0]     norm_gain,
  input  logic [GAIN_W-1:0]     boost_gain,
  input  logic [CSR_W-1:0]      slip_code,
  output logic [GAIN_W-1:0]     gain_code,
  output logic [(1<<CSR_W)-1:0] cmp_div,
  output logic                  loop_sw,
  output logic                  busy
);
  localparam int DIV_W = 1 << CSR_W;

  logic expire;
  logic to_nonzero;

  assign to_nonzero = (timeout != '0);

  acq_timer #(.TO_W(TO_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tune),
    .load_val (timeout),
    .tick     (ref_tick),
    .expire   (expire)
  );

  acq_seq i_seq (
    .clk        (clk),
    .rst        (rst),
    .tune       (tune),
    .to_nonzero (to_nonzero),
    .expire     (expire),
    .busy       (busy)
  );

  acq_out_map #(.GAIN_W(GAIN_W), .CSR_W(CSR_W)) i_map (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .norm_gain  (norm_gain),
    .boost_gain (boost_gain),
    .slip_code  (slip_code),
    .gain_code  (gain_code),
    .cmp_div    (cmp_div),
    .loop_sw    (loop_sw)
  );

  AST_RETURN_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(loop_sw) |-> (gain_code == norm_gain && cmp_div == DIV_W'(1))); // R8

  AST_SWITCH_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    loop_sw == busy); // R8
endmodule

// File: tb/test_acq_boost_ctrl.sv
module test_acq_boost_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        tune = 1'b0;
  logic [13:0] timeout = '0;
  logic [1:0]  norm_gain = 2'd0;
  logic [1:0]  boost_gain = 2'd0;
  logic [1:0]  slip_code = 2'd0;
  logic [1:0]  gain_code;
  logic [3:0]  cmp_div;
  logic        loop_sw;
  logic        busy;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  acq_boost_ctrl i_acq_boost_ctrl (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .tune(tune), .timeout(timeout),
    .norm_gain(norm_gain), .boost_gain(boost_gain), .slip_code(slip_code),
    .gain_code(gain_code), .cmp_div(cmp_div), .loop_sw(loop_sw), .busy(busy)
  );

  // fields: timeout[23:10] boost_gain[9:8] norm_gain[7:6] slip_code[5:4] expected cmp_div[3:0]
  localparam logic [23:0] VEC [0:5] = '{
    {14'd1, 2'd3, 2'd0, 2'd0, 4'd1},
    {14'd2, 2'd2, 2'd1, 2'd1, 4'd2},
    {14'd3, 2'd3, 2'd1, 2'd2, 4'd4},
    {14'd4, 2'd1, 2'd0, 2'd3, 4'd8},
    {14'd5, 2'd3, 2'd2, 2'd3, 4'd8},
    {14'd2, 2'd0, 2'd3, 2'd2, 4'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: inputs applied at a falling edge, outputs read at the next falling edge
  task automatic step(input logic tn, input logic tk);
    tune = tn;
    ref_tick = tk;
    @(negedge clk);
    tune = 1'b0;
    ref_tick = 1'b0;
  endtask

  task automatic idle_tick();
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    rst = 1'b0;
    norm_gain = 2'd2;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 loop_sw after reset", loop_sw, 0);
    chk("R1 gain after reset", gain_code, 2);
    chk("R1 div after reset", cmp_div, 1);
    idle_tick();
    chk("R1 ticks do not start boost", busy, 0);

    // table-driven sweep of the main function
    for (int v = 0; v < 6; v++) begin
      int t;
      t = int'(VEC[v][23:10]);
      timeout = VEC[v][23:10];
      boost_gain = VEC[v][9:8];
      norm_gain = VEC[v][7:6];
      slip_code = VEC[v][5:4];
      step(1'b1, 1'b0);
      chk("R2 busy after tune", busy, 1);
      chk("R2 loop_sw after tune", loop_sw, 1);
      chk("R3 boost gain", gain_code, int'(VEC[v][9:8]));
      chk("R4 boost div", cmp_div, int'(VEC[v][3:0]));
      for (int k = 1; k < t; k++) idle_tick();
      chk("R5 still busy before last tick", busy, 1);
      step(1'b0, 1'b1);
      chk("R5 busy ends on last tick", busy, 0);
      chk("R8 loop_sw returns", loop_sw, 0);
      chk("R8 gain returns", gain_code, int'(VEC[v][7:6]));
      chk("R8 div returns", cmp_div, 1);
    end

    norm_gain = 2'd1;
    #1;
    chk("R3 normal gain tracks norm_gain", gain_code, 1);

    // R6: zero timeout, from idle and during a boost
    timeout = 14'd0;
    step(1'b1, 1'b0);
    chk("R6 zero timeout stays normal", busy, 0);
    timeout = 14'd5;
    step(1'b1, 1'b0);
    idle_tick();
    timeout = 14'd0;
    step(1'b1, 1'b0);
    chk("R6 zero timeout ends boost", busy, 0);
    idle_tick();
    chk("R6 counter cleared", busy, 0);

    // R7: restart during the boost
    timeout = 14'd3;
    step(1'b1, 1'b0);
    idle_tick();
    idle_tick();
    step(1'b1, 1'b0);
    idle_tick();
    idle_tick();
    chk("R7 restart keeps boost after 2 ticks", busy, 1);
    idle_tick();
    chk("R7 restart ends after full count", busy, 0);

    // R9: a tick together with tune is not counted
    timeout = 14'd2;
    step(1'b1, 1'b1);
    idle_tick();
    chk("R9 simultaneous tick not counted", busy, 1);
    idle_tick();
    chk("R9 ends after two ticks", busy, 0);

    // R11: timeout changes after tune are ignored
    timeout = 14'd2;
    step(1'b1, 1'b0);
    timeout = 14'd9;
    idle_tick();
    chk("R11 still busy", busy, 1);
    idle_tick();
    chk("R11 ends at captured count", busy, 0);

    // R1: reset during a boost
    timeout = 14'd4;
    step(1'b1, 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b0);
    rst = 1'b0;
    chk("R1 reset ends boost", busy, 0);
    idle_tick();
    chk("R1 counter cleared by reset", busy, 0);

    // R10: largest timeout
    timeout = 14'd16383;
    step(1'b1, 1'b0);
    for (int k = 1; k < 16383; k++) step(1'b0, 1'b1);
    chk("R10 busy before tick 16383", busy, 1);
    step(1'b0, 1'b1);
    chk("R10 ends at tick 16383", busy, 0);

    finish_run();
  end
endmodule